// File: doc/BRIEF.md
# Lane-Striped Packet Framing Tracker

This block sits after the 8b/10b decoders of a 1-, 2- or 4-lane serial link receiver. Each cycle it takes one decoded byte and one control-symbol flag per lane. It treats the active lanes as consecutive symbols of one stream, with lane 0 first. It walks that stream in order and follows the packet delimiters. Transaction-layer packets open with their own start delimiter. Data-link packets open with a different start delimiter. Both close with a shared end delimiter.

For every active lane position, the tracker reports whether that symbol opened a packet of either kind, closed a packet, broke the framing rules, or was packet body. It also reports which state the link is in at the end of the cycle: inside a transaction packet, inside a data-link packet, inside an ordered set, or idle. Ordered sets start with the comma symbol and are replicated on every lane. Their symbols never count as packet content. All outputs are registered and appear one cycle after the input cycle.

Top module: `lane_frame_tracker`

## Requirements
- R1: While rst_n is low at a clock edge, the state after that edge is idle: every output bit is 0.
- R2: The link width is taken from cfg_lanes only at edges where rst_n is low. The value 2 selects x2 and the value 4 selects x4. Any other value selects x1. A change of cfg_lanes while rst_n is high has no effect.
- R3: Within one cycle, symbols are handled in lane order 0, 1, … up to the width minus 1. The state left by lane i is the state seen by lane i+1, so several delimiters in one cycle act in sequence.
- R4: A symbol with K set and byte 0x5C, seen while idle or in an ordered set, opens a data-link packet. It sets sop_dllp at its lane position, and dllp_active reads 1 afterwards.
- R5: A symbol with K set and byte 0xFB, seen while idle or in an ordered set, opens a transaction packet. It sets sop_tlp at its lane position, and tlp_active reads 1 afterwards.
- R6: A symbol with K set and byte 0xFD, seen while a packet is open, closes that packet. It sets eop at its lane position, and the tracker returns to idle.
- R7: pkt_body is set at a lane position exactly when a packet is open and the symbol there is not a delimiter or comma. A delimiter byte value with K clear counts as plain data.
- R8: Any of the following sets frm_err at that lane position and leaves the tracker idle: an end delimiter while no packet is open (idle or ordered set), or a start delimiter while a packet is open.
- R9: A symbol with K set and byte 0xBC enters the ordered-set state (os_active=1). If a packet was open, it also sets frm_err at that position. In the ordered-set state, the following symbols are ignored until a delimiter arrives.
- R10: Lanes at or above the configured width have no effect on the state. Their output bits are always 0.
- R11: In a cycle with in_valid low, all per-lane outputs are 0 and the state is held.
- R12: Outputs for an input cycle appear after the next rising clock edge and last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_lanes | input | 3 | Link width code, sampled during reset |
| in_valid | input | 1 | The lane symbols of this cycle are valid |
| rx_data | input | 32 | Decoded byte per lane, lane 0 in bits 7:0 |
| rx_k | input | 4 | Control-symbol flag per lane |
| tlp_active | output | 1 | A transaction packet is open |
| dllp_active | output | 1 | A data-link packet is open |
| os_active | output | 1 | The stream is inside an ordered set |
| sop_tlp | output | 4 | Transaction packet opened at this lane position |
| sop_dllp | output | 4 | Data-link packet opened at this lane position |
| eop | output | 4 | Packet closed at this lane position |
| frm_err | output | 4 | Framing violation at this lane position |
| pkt_body | output | 4 | Symbol at this lane position is packet body |

## Verification
On a x1 link, whole packets are sent one symbol per cycle. This shows that state carries across cycles. Wide-lane patterns place a close and a new open in the same cycle, and put packet boundaries at every lane position. These separate true in-order handling from a per-lane or per-cycle approximation. Misplaced delimiters, commas inside packets, delimiter bytes with K clear, and garbage on lanes beyond the width each target a single rule. An invalid width code and a width change after reset confirm that the width is latched only during reset.

// File: rtl/lft_pkg.sv
// Shared symbol codes, state encoding and width decode for the framing tracker.
package lft_pkg;
    localparam int SYM_W = 8;

    localparam logic [SYM_W-1:0] CODE_DLLP_OPEN = 8'h5C;
    localparam logic [SYM_W-1:0] CODE_TLP_OPEN  = 8'hFB;
    localparam logic [SYM_W-1:0] CODE_PKT_CLOSE = 8'hFD;
    localparam logic [SYM_W-1:0] CODE_COMMA     = 8'hBC;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_TLP  = 2'd1,
        FS_DLLP = 2'd2,
        FS_OSET = 2'd3
    } frame_st_t;

    typedef struct packed {
        logic sop_tlp;
        logic sop_dllp;
        logic eop;
        logic err;
        logic body;
    } sym_flags_t;

    // Width code to lane count; unknown or unsupported codes give one lane.
    function automatic int unsigned lanes_from_cfg(input logic [2:0] code,
                                                   input int unsigned max_lanes);
        int unsigned n;
        case (code)
            3'd2:    n = 2;
            3'd4:    n = 4;
            default: n = 1;
        endcase
        if (n > max_lanes) n = 1;
        return n;
    endfunction
endpackage

// File: rtl/lft_width_latch.sv
// Holds the per-lane enable mask of the link.
// Assumes: cfg_lanes is meaningful only while rst_n is low; the mask is held afterwards.
module lft_width_latch #(
    parameter int MAX_LANES = 4,
    parameter int CFG_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CFG_W-1:0]     cfg_lanes,
    output logic [MAX_LANES-1:0] lane_en
);
    import lft_pkg::*;

    logic [MAX_LANES-1:0] mask_d;

    // Expand the width code into a contiguous enable mask from lane 0 upward.
    always_comb begin
        int unsigned cnt;
        cnt = lanes_from_cfg(3'(cfg_lanes), MAX_LANES);
        for (int i = 0; i < MAX_LANES; i++) begin
            mask_d[i] = (i < cnt);
        end
    end

    // Load the mask during reset, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) lane_en <= mask_d;
    end
endmodule

// File: rtl/lft_sym_step.sv
// Applies one symbol to the framing state and reports what that symbol was.
// Assumes: purely combinational; a disabled step passes the state through with no flags.
module lft_sym_step (
    input  lft_pkg::frame_st_t         st_in,
    input  logic [lft_pkg::SYM_W-1:0]  sym,
    input  logic                       is_k,
    input  logic                       en,
    output lft_pkg::frame_st_t         st_out,
    output lft_pkg::sym_flags_t        flags
);
    import lft_pkg::*;

    logic pkt_open;
    assign pkt_open = (st_in == FS_TLP) || (st_in == FS_DLLP);

    // Next state and symbol classification for one lane position.
    always_comb begin
        st_out = st_in;
        flags  = '0;
        if (en) begin
            if (is_k && sym == CODE_DLLP_OPEN) begin
                if (pkt_open) begin
                    flags.err = 1'b1;
                    st_out    = FS_IDLE;
                end else begin
                    flags.sop_dllp = 1'b1;
                    st_out         = FS_DLLP;
                end
            end else if (is_k && sym == CODE_TLP_OPEN) begin
                if (pkt_open) begin
                    flags.err = 1'b1;
                    st_out    = FS_IDLE;
                end else begin
                    flags.sop_tlp = 1'b1;
                    st_out        = FS_TLP;
                end
            end else if (is_k && sym == CODE_PKT_CLOSE) begin
                if (pkt_open) flags.eop = 1'b1;
                else          flags.err = 1'b1;
                st_out = FS_IDLE;
            end else if (is_k && sym == CODE_COMMA) begin
                flags.err = pkt_open;
                st_out    = FS_OSET;
            end else begin
                flags.body = pkt_open;
            end
        end
    end
endmodule

// File: rtl/lft_lane_chain.sv
// Walks the lanes of one cycle in symbol order, lane 0 first.
// Assumes: lane i's byte sits in rx_data[i*SYM_W +: SYM_W]; disabled lanes pass state through.
module lft_lane_chain #(
    parameter int MAX_LANES = 4
) (
    input  lft_pkg::frame_st_t                   st_start,
    input  logic [MAX_LANES*lft_pkg::SYM_W-1:0]  rx_data,
    input  logic [MAX_LANES-1:0]                 rx_k,
    input  logic [MAX_LANES-1:0]                 lane_go,
    output lft_pkg::frame_st_t                   st_end,
    output logic [MAX_LANES-1:0]                 f_sop_tlp,
    output logic [MAX_LANES-1:0]                 f_sop_dllp,
    output logic [MAX_LANES-1:0]                 f_eop,
    output logic [MAX_LANES-1:0]                 f_err,
    output logic [MAX_LANES-1:0]                 f_body
);
    import lft_pkg::*;

    frame_st_t  st_w [MAX_LANES+1];
    sym_flags_t fl_w [MAX_LANES];

    assign st_w[0] = st_start;
    assign st_end  = st_w[MAX_LANES];

    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
        lft_sym_step u_step (
            .st_in  (st_w[g]),
            .sym    (rx_data[g*SYM_W +: SYM_W]),
            .is_k   (rx_k[g]),
            .en     (lane_go[g]),
            .st_out (st_w[g+1]),
            .flags  (fl_w[g])
        );
        assign f_sop_tlp[g]  = fl_w[g].sop_tlp;
        assign f_sop_dllp[g] = fl_w[g].sop_dllp;
        assign f_eop[g]      = fl_w[g].eop;
        assign f_err[g]      = fl_w[g].err;
        assign f_body[g]     = fl_w[g].body;
    end
endmodule

// File: rtl/lane_frame_tracker.sv
// Top of the framing tracker: latches the width, runs the lane chain, registers results.
// Assumes: synchronous active-low reset; inputs are decoded symbols aligned across lanes.
module lane_frame_tracker #(
    parameter int MAX_LANES = 4,
    parameter int CFG_W     = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [CFG_W-1:0]                    cfg_lanes,
    input  logic                                in_valid,
    input  logic [MAX_LANES*lft_pkg::SYM_W-1:0] rx_data,
    input  logic [MAX_LANES-1:0]                rx_k,
    output logic                                tlp_active,
    output logic                                dllp_active,
    output logic                                os_active,
    output logic [MAX_LANES-1:0]                sop_tlp,
    output logic [MAX_LANES-1:0]                sop_dllp,
    output logic [MAX_LANES-1:0]                eop,
    output logic [MAX_LANES-1:0]                frm_err,
    output logic [MAX_LANES-1:0]                pkt_body
);
    import lft_pkg::*;

    logic [MAX_LANES-1:0] lane_en;
    logic [MAX_LANES-1:0] lane_go;
    frame_st_t            st_q;
    frame_st_t            st_n;
    logic [MAX_LANES-1:0] c_sop_tlp, c_sop_dllp, c_eop, c_err, c_body;

    lft_width_latch #(.MAX_LANES(MAX_LANES), .CFG_W(CFG_W)) u_width (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_lanes (cfg_lanes),
        .lane_en   (lane_en)
    );

    // A lane takes part only when enabled by the width and the cycle is valid.
    assign lane_go = lane_en & {MAX_LANES{in_valid}};

    lft_lane_chain #(.MAX_LANES(MAX_LANES)) u_chain (
        .st_start   (st_q),
        .rx_data    (rx_data),
        .rx_k       (rx_k),
        .lane_go    (lane_go),
        .st_end     (st_n),
        .f_sop_tlp  (c_sop_tlp),
        .f_sop_dllp (c_sop_dllp),
        .f_eop      (c_eop),
        .f_err      (c_err),
        .f_body     (c_body)
    );

    // Register the framing state and the per-lane flags of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= FS_IDLE;
            sop_tlp  <= '0;
            sop_dllp <= '0;
            eop      <= '0;
            frm_err  <= '0;
            pkt_body <= '0;
        end else begin
            st_q     <= st_n;
            sop_tlp  <= c_sop_tlp;
            sop_dllp <= c_sop_dllp;
            eop      <= c_eop;
            frm_err  <= c_err;
            pkt_body <= c_body;
        end
    end

    // Decode the registered state into the level outputs.
    always_comb begin
        tlp_active  = (st_q == FS_TLP);
        dllp_active = (st_q == FS_DLLP);
        os_active   = (st_q == FS_OSET);
    end
endmodule

// File: rtl/lft_checker.sv
// Temporal checks on the framing tracker, attached by bind.
module lft_checker #(
    parameter int MAX_LANES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [MAX_LANES-1:0] lane_en,
    input logic                 tlp_active,
    input logic                 dllp_active,
    input logic                 os_active,
    input logic [MAX_LANES-1:0] sop_tlp,
    input logic [MAX_LANES-1:0] sop_dllp,
    input logic [MAX_LANES-1:0] eop,
    input logic [MAX_LANES-1:0] frm_err,
    input logic [MAX_LANES-1:0] pkt_body
);
    logic [MAX_LANES-1:0] any_flag;
    assign any_flag = sop_tlp | sop_dllp | eop | frm_err | pkt_body;

    // R1: a reset edge leaves every output at zero.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (any_flag == '0) && !tlp_active && !dllp_active && !os_active);

    // R2: the width mask never moves outside reset.
    a_r2_width_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(lane_en));

    // R10: lanes beyond the width never report anything.
    a_r10_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (any_flag & ~lane_en) == '0);

    // R11: an invalid cycle yields no flags and holds the state.
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (any_flag == '0) && $stable({tlp_active, dllp_active, os_active}));

    // R7: a body symbol is never also a delimiter or an error.
    a_r7_body_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_body & (sop_tlp | sop_dllp | eop | frm_err)) == '0);

    // R9: at most one of the level states is reported.
    a_r9_one_state: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tlp_active, dllp_active, os_active}));
endmodule

bind lane_frame_tracker lft_checker #(.MAX_LANES(MAX_LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .lane_en     (lane_en),
    .tlp_active  (tlp_active),
    .dllp_active (dllp_active),
    .os_active   (os_active),
    .sop_tlp     (sop_tlp),
    .sop_dllp    (sop_dllp),
    .eop         (eop),
    .frm_err     (frm_err),
    .pkt_body    (pkt_body)
);

// File: tb/tb_lane_frame_tracker.sv
// Scoreboard bench: the driver computes expectations from the requirements,
// the monitor compares them one cycle later.
module tb_lane_frame_tracker;
    localparam int  CLK_PERIOD = 10;
    localparam int  NL = 4;
    localparam logic [7:0] SDP = 8'h5C;
    localparam logic [7:0] STP = 8'hFB;
    localparam logic [7:0] ENDS = 8'hFD;
    localparam logic [7:0] COM = 8'hBC;
    localparam logic [7:0] DAT = 8'h3A;

    typedef struct {
        logic       tlp, dllp, os;
        logic [3:0] st, sd, ep, er, bd;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_lanes = 3'd1;
    logic        in_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic [3:0]  rx_k = '0;
    logic        tlp_active, dllp_active, os_active;
    logic [3:0]  sop_tlp, sop_dllp, eop, frm_err, pkt_body;

    int checks = 0;
    int failures = 0;
    exp_t q[$];
    int m_state = 0;   // 0 idle, 1 tlp, 2 dllp, 3 ordered set
    int m_width = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_frame_tracker dut (
        .clk(clk), .rst_n(rst_n), .cfg_lanes(cfg_lanes), .in_valid(in_valid),
        .rx_data(rx_data), .rx_k(rx_k), .tlp_active(tlp_active),
        .dllp_active(dllp_active), .os_active(os_active), .sop_tlp(sop_tlp),
        .sop_dllp(sop_dllp), .eop(eop), .frm_err(frm_err), .pkt_body(pkt_body)
    );

    task automatic report(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Drive one input cycle and push its expected outputs (R3..R12 model).
    task automatic cyc(input logic v, input logic [31:0] d, input logic [3:0] k, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = v; rx_data = d; rx_k = k;
        e.st = 0; e.sd = 0; e.ep = 0; e.er = 0; e.bd = 0; e.tag = tag;
        for (int i = 0; i < m_width; i++) begin
            logic [7:0] b;
            logic open;
            if (!v) break;
            b = d[i*8 +: 8];
            open = (m_state == 1) || (m_state == 2);
            if (k[i] && b == SDP) begin
                if (open) begin e.er[i] = 1; m_state = 0; end
                else begin e.sd[i] = 1; m_state = 2; end
            end else if (k[i] && b == STP) begin
                if (open) begin e.er[i] = 1; m_state = 0; end
                else begin e.st[i] = 1; m_state = 1; end
            end else if (k[i] && b == ENDS) begin
                if (open) e.ep[i] = 1; else e.er[i] = 1;
                m_state = 0;
            end else if (k[i] && b == COM) begin
                e.er[i] = open;
                m_state = 3;
            end else begin
                e.bd[i] = open;
            end
        end
        e.tlp = (m_state == 1); e.dllp = (m_state == 2); e.os = (m_state == 3);
        q.push_back(e);
    endtask

    // Apply reset with a given width code and check the cleared outputs (R1, R2).
    task automatic do_reset(input logic [2:0] code);
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0; cfg_lanes = code;
        @(negedge clk);
        @(negedge clk);
        report("R1", "outputs in reset",
               int'({tlp_active, dllp_active, os_active, sop_tlp, sop_dllp, eop, frm_err, pkt_body}), 0);
        m_state = 0;
        m_width = (code == 3'd2) ? 2 : (code == 3'd4) ? 4 : 1;
        rst_n = 1'b1;
    endtask

    // Monitor: compare after the edge that registered each driven cycle (R12).
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                report(e.tag, "tlp_active", tlp_active, e.tlp);
                report(e.tag, "dllp_active", dllp_active, e.dllp);
                report(e.tag, "os_active", os_active, e.os);
                report(e.tag, "sop_tlp", sop_tlp, e.st);
                report(e.tag, "sop_dllp", sop_dllp, e.sd);
                report(e.tag, "eop", eop, e.ep);
                report(e.tag, "frm_err", frm_err, e.er);
                report(e.tag, "pkt_body", pkt_body, e.bd);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // x1 link: packets spread over cycles
        do_reset(3'd1);
        cyc(1, {24'h0, STP}, 4'b0001, "R5");
        cyc(1, {24'h0, DAT}, 4'b0000, "R7");
        cyc(1, {24'h0, ENDS}, 4'b0000, "R7");   // END byte with K clear is body
        cyc(1, {24'h0, ENDS}, 4'b0001, "R6");
        cyc(1, {24'h0, SDP}, 4'b0001, "R4");
        cyc(0, {24'h0, ENDS}, 4'b0001, "R11");  // ignored while invalid
        cyc(1, {24'h0, DAT}, 4'b0000, "R7");
        cyc(1, {24'h0, ENDS}, 4'b0001, "R6");
        cyc(1, {24'h0, DAT}, 4'b0000, "R7");    // idle data, not body
        cyc(1, {24'h0, ENDS}, 4'b0001, "R8");   // END while idle
        cyc(1, {24'h0, STP}, 4'b0001, "R5");
        cyc(1, {24'h0, SDP}, 4'b0001, "R8");    // start while open
        cyc(1, {24'h0, DAT}, 4'b0000, "R8");
        cyc(1, {24'h0, COM}, 4'b0001, "R9");
        cyc(1, {24'h0, DAT}, 4'b0000, "R9");
        cyc(1, {24'h0, ENDS}, 4'b0001, "R9");   // END in ordered set
        cyc(1, {24'h0, COM}, 4'b0001, "R9");
        cyc(1, {24'h0, STP}, 4'b0001, "R9");    // start ends ordered set
        cyc(1, {24'h0, COM}, 4'b0001, "R9");    // comma inside packet
        // width code changed outside reset: still x1
        @(negedge clk); cfg_lanes = 3'd4;
        cyc(1, {STP, SDP, STP, DAT}, 4'b1110, "R2");
        cyc(1, {ENDS, ENDS, ENDS, SDP}, 4'b1111, "R10");
        cyc(1, {24'h0, ENDS}, 4'b0001, "R6");

        // x4 link: several delimiters per cycle
        do_reset(3'd4);
        cyc(1, {ENDS, DAT, DAT, SDP}, 4'b1001, "R3");
        cyc(1, {DAT, DAT, DAT, STP}, 4'b0001, "R5");
        cyc(1, {SDP, ENDS, DAT, DAT}, 4'b1100, "R3");
        cyc(1, {ENDS, DAT, DAT, DAT}, 4'b1000, "R6");
        cyc(1, {COM, COM, COM, COM}, 4'b1111, "R9");
        cyc(1, {DAT, DAT, DAT, DAT}, 4'b0000, "R9");
        cyc(1, {DAT, DAT, STP, DAT}, 4'b0010, "R3");
        cyc(1, {DAT, STP, DAT, ENDS}, 4'b0101, "R8");
        cyc(1, {DAT, COM, DAT, SDP}, 4'b0101, "R9");
        cyc(0, {STP, STP, STP, STP}, 4'b1111, "R11");
        cyc(1, {ENDS, DAT, ENDS, SDP}, 4'b1011, "R8");

        // x2 link
        do_reset(3'd2);
        cyc(1, {STP, STP, DAT, STP}, 4'b1101, "R10");
        cyc(1, {SDP, SDP, ENDS, DAT}, 4'b1110, "R10");
        cyc(1, {DAT, DAT, SDP, ENDS}, 4'b0011, "R8");
        cyc(1, {DAT, DAT, ENDS, DAT}, 4'b0010, "R6");

        // unsupported width code falls back to x1
        do_reset(3'd3);
        cyc(1, {DAT, DAT, STP, SDP}, 4'b0011, "R2");
        cyc(1, {DAT, DAT, ENDS, ENDS}, 4'b0011, "R2");

        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule